// File: doc/BRIEF.md
# Link/Activity LED Status Driver

This block drives a pair of active-low indicator pins from the state of an Ethernet port. Its inputs are a link-up flag, a 2-bit negotiated speed (10, 100 or 1000 Mbps) and single-cycle activity strobes from the transmit and receive paths. A mode strap is captured while reset is held and selects one of two display schemes. In the single scheme, one pin shows link and the other shows activity. In the tri-color dual scheme, the combination of lit pins encodes the speed, and during activity only the lit pins blink.

Each activity strobe reloads a retriggerable stretch counter, so even one strobe produces at least one full on/off blink period. A free-running prescaler sets the blink rate. Both pins are registered, so every input change shows at the pins one clock later. When the link drops, the stretch counter is cleared. A speed change while link is up changes the steady pattern at once and leaves any running activity stretch in place.

Top module: `led_status_drv`

## Requirements
- R1: While `rst_n` is low, both pins are high, and `mode_strap` is captured (0 selects single mode, 1 selects dual mode). After reset is released the captured mode is held, and later changes on `mode_strap` have no effect.
- R2: In single mode, `led_link_n` is low one clock after `link_up` is 1, at any speed. It is high one clock after `link_up` is 0.
- R3: In single mode, `led_act_n` is high when there is no activity. While activity is stretched, it alternates between low and high, with each phase lasting `BLINK_HALF` cycles.
- R4: In dual mode with `link_up` at 0, both pins are high.
- R5: In dual mode at 1000 Mbps (`speed` = 2'b10 or 2'b11), `led_link_n` is low and `led_act_n` is high. During activity, `led_link_n` blinks and `led_act_n` stays high.
- R6: In dual mode at 100 Mbps (`speed` = 2'b01), `led_link_n` is high and `led_act_n` is low. During activity, `led_act_n` blinks and `led_link_n` stays high.
- R7: In dual mode at 10 Mbps (`speed` = 2'b00), both pins are low. During activity, both pins blink together and are equal on every cycle.
- R8: A `tx_act` or `rx_act` strobe taken while link is up reloads the stretch counter to `max(STRETCH, 2*BLINK_HALF)` cycles. A further strobe retriggers the counter. Without strobes, activity ends when the counter runs out and the pins return to their steady pattern.
- R9: While `link_up` is 0, the stretch counter is cleared and activity strobes are ignored. On a link drop, both pins go high on the next clock. When link returns, the pins show the steady pattern with no blinking.
- R10: A change of `speed` while link is up shows in the steady pattern on the next clock, and the activity stretch already running continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the strap is sampled while it is low |
| mode_strap | input | 1 | Display scheme strap: 0 single, 1 tri-color dual |
| link_up | input | 1 | Link is established |
| speed | input | 2 | Negotiated speed: 00 = 10, 01 = 100, 1x = 1000 Mbps |
| tx_act | input | 1 | One-cycle transmit activity strobe |
| rx_act | input | 1 | One-cycle receive activity strobe |
| led_act_n | output | 1 | Indicator pin 1, low = lit |
| led_link_n | output | 1 | Indicator pin 2, low = lit |

## Verification
The assertions assume that `mode_strap` is valid during the clocks in which reset is held. They also assume that `speed` has meaning only while `link_up` is 1, and that the stretch length covers at least one full blink period. The bench holds the strap steady through each reset and overrides the parameters to a 4-cycle blink phase and a 16-cycle stretch. It drives every input on the falling edge, one speed or link change at a time. Blink checks do not predict the prescaler phase. Each one counts lit and dark samples over a window longer than a full period and checks that the pins which must stay dark never light.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic {
    LED_SINGLE = 1'b0,
    LED_DUAL   = 1'b1
  } led_mode_e;

  // Effective stretch length: never shorter than one full blink period.
  function automatic int unsigned stretch_len(input int unsigned stretch,
                                              input int unsigned half);
    return (stretch < 2 * half) ? 2 * half : stretch;
  endfunction

  // Lit pattern {link_pin, act_pin} for dual mode at a given speed code.
  function automatic logic [1:0] speed_lit(input logic [1:0] spd);
    logic [1:0] lit;
    case (spd)
      2'b00:   lit = 2'b11;  // 10 Mbps: both lit
      2'b01:   lit = 2'b01;  // 100 Mbps: act pin only
      default: lit = 2'b10;  // 1000 Mbps: link pin only
    endcase
    return lit;
  endfunction

  // Pin levels {link_n, act_n}; dark_ph is the dark half of the blink period.
  function automatic logic [1:0] pin_levels(input led_mode_e mode,
                                            input logic link,
                                            input logic [1:0] spd,
                                            input logic busy,
                                            input logic dark_ph);
    logic [1:0] lit;
    logic       act;
    act = busy & link;
    if (mode == LED_SINGLE) begin
      lit = {link, act & ~dark_ph};
    end else if (!link) begin
      lit = 2'b00;
    end else begin
      lit = speed_lit(spd) & {2{~(act & dark_ph)}};
    end
    return ~lit;
  endfunction

endpackage

// File: rtl/led_mode_latch.sv
module led_mode_latch
  import led_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strap,
  output led_mode_e mode
);

  led_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= led_mode_e'(strap);
  end

  assign mode = mode_q;

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic tx_stb,
  input  logic rx_stb,
  output logic busy,
  output logic hit
);

  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  assign hit  = (tx_stb | rx_stb) & link_up;
  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !link_up) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= CW'(LEN);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> busy);

  // R8
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hit) |=> !busy);

  // R9
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !busy);

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic dark_ph,
  output logic wrap
);

  localparam int unsigned PW = $clog2(HALF + 1);

  logic [PW-1:0] pre_q;
  logic          ph_q;

  assign wrap    = (pre_q == PW'(HALF - 1));
  assign dark_ph = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= 1'b0;
    end else if (wrap) begin
      pre_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R3
  flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ph_q != $past(ph_q)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ph_q));

endmodule

// File: rtl/led_pin_map.sv
module led_pin_map
  import led_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  led_mode_e  mode,
  input  logic       link_up,
  input  logic [1:0] speed,
  input  logic       busy,
  input  logic       dark_ph,
  output logic       link_n,
  output logic       act_n
);

  logic [1:0] pins_d;
  logic [1:0] pins_q;

  assign pins_d = pin_levels(mode, link_up, speed, busy, dark_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= 2'b11;
    else        pins_q <= pins_d;
  end

  assign link_n = pins_q[1];
  assign act_n  = pins_q[0];

  // R1
  rst_dark_chk: assert property (@(posedge clk)
    !rst_n |=> (link_n && act_n));

  // R2
  single_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_SINGLE && link_up) |=> !link_n);

  // R3
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_SINGLE && !busy) |=> act_n);

  // R4
  dual_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_DUAL && !link_up) |=> (link_n && act_n));

  // R5
  dual_giga_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_DUAL && link_up && speed[1]) |=> act_n);

  // R6
  dual_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_DUAL && link_up && speed == 2'b01) |=> link_n);

  // R7
  dual_ten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_DUAL && link_up && speed == 2'b00) |=> (link_n == act_n));

  // R9
  drop_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (act_n && (mode == LED_SINGLE || link_n)));

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_status_pkg::*;
#(
  parameter int unsigned BLINK_HALF = 6250000,
  parameter int unsigned STRETCH    = 12500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_strap,
  input  logic       link_up,
  input  logic [1:0] speed,
  input  logic       tx_act,
  input  logic       rx_act,
  output logic       led_act_n,
  output logic       led_link_n
);

  localparam int unsigned HALF_EFF = (BLINK_HALF < 2) ? 2 : BLINK_HALF;
  localparam int unsigned LEN      = stretch_len(STRETCH, HALF_EFF);

  led_mode_e mode;
  logic      act_busy;
  logic      act_hit;
  logic      dark_ph;
  logic      blink_wrap;

  led_mode_latch u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (mode_strap),
    .mode  (mode)
  );

  led_act_stretch #(.LEN(LEN)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .tx_stb  (tx_act),
    .rx_stb  (rx_act),
    .busy    (act_busy),
    .hit     (act_hit)
  );

  led_blink_gen #(.HALF(HALF_EFF)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .dark_ph (dark_ph),
    .wrap    (blink_wrap)
  );

  led_pin_map u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .link_up (link_up),
    .speed   (speed),
    .busy    (act_busy),
    .dark_ph (dark_ph),
    .link_n  (led_link_n),
    .act_n   (led_act_n)
  );

  // R10
  speed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && $past(link_up) && speed != $past(speed) && $past(act_busy)
     && !$past(act_hit) && !act_hit) |-> act_busy || !$past(act_busy, 1));

  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_act || rx_act) && link_up) |=> act_busy);

  // R3
  wrap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blink_wrap |=> !blink_wrap);

endmodule

// File: tb/test_led_status_drv.sv
module test_led_status_drv;

  localparam int unsigned HALF = 4;
  localparam int unsigned LEN  = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_strap;
  logic       link_up;
  logic [1:0] speed;
  logic       tx_act;
  logic       rx_act;
  logic       led_act_n;
  logic       led_link_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Window counters
  int lit_a, dark_a, lit_l, dark_l, uneq;

  always #5 clk = ~clk;

  led_status_drv #(.BLINK_HALF(HALF), .STRETCH(LEN)) i_led_status_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_strap (mode_strap),
    .link_up    (link_up),
    .speed      (speed),
    .tx_act     (tx_act),
    .rx_act     (rx_act),
    .led_act_n  (led_act_n),
    .led_link_n (led_link_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pins(input string tag, input logic ln, input logic an);
    check({led_link_n, led_act_n} == {ln, an}, tag,
          int'({led_link_n, led_act_n}), int'({ln, an}));
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n);
    lit_a = 0; dark_a = 0; lit_l = 0; dark_l = 0; uneq = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (led_act_n) dark_a++; else lit_a++;
      if (led_link_n) dark_l++; else lit_l++;
      if (led_act_n != led_link_n) uneq++;
    end
  endtask

  task automatic strobe(input bit use_rx);
    if (use_rx) rx_act = 1'b1; else tx_act = 1'b1;
    step(1);
    rx_act = 1'b0; tx_act = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; mode_strap = strap; link_up = 1'b0; speed = 2'b00;
    tx_act = 1'b0; rx_act = 1'b0;
    step(3);
    pins("R1 pins high in reset", 1'b1, 1'b1);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_single_link;
    do_reset(1'b0);
    pins("R1 pins high after reset", 1'b1, 1'b1);
    link_up = 1'b1; speed = 2'b00; step(1);
    pins("R2 single link 10", 1'b0, 1'b1);
    speed = 2'b10; step(1);
    pins("R2 single link 1000", 1'b0, 1'b1);
    watch(12);
    check(lit_a == 0, "R3 act dark without activity", lit_a, 0);
    link_up = 1'b0; step(1);
    pins("R2 single link down", 1'b1, 1'b1);
  endtask

  task automatic t_single_act;
    do_reset(1'b0);
    link_up = 1'b1; speed = 2'b01; step(2);
    strobe(1'b0);
    watch(LEN + 2);
    check(lit_a > 0 && dark_a > 0, "R3 act blinks", lit_a, 1);
    check(dark_l == 0, "R2 link lit during activity", dark_l, 0);
    check(lit_a >= int'(HALF), "R8 at least one full period", lit_a, HALF);
    watch(10);
    check(lit_a == 0, "R8 stretch ends", lit_a, 0);
    for (int k = 0; k < 5; k++) begin
      strobe(1'b1);
      step(11);
    end
    watch(10);
    check(lit_a > 0, "R8 retrigger keeps blinking", lit_a, 1);
    step(LEN + 4);
    pins("R8 steady after retrigger run", 1'b0, 1'b1);
  endtask

  task automatic t_strap_hold;
    do_reset(1'b0);
    mode_strap = 1'b1;
    link_up = 1'b1; speed = 2'b01; step(2);
    pins("R1 strap change ignored", 1'b0, 1'b1);
  endtask

  task automatic t_dual;
    do_reset(1'b1);
    pins("R4 dual no link", 1'b1, 1'b1);
    strobe(1'b0);
    watch(LEN + 4);
    check(lit_a == 0 && lit_l == 0, "R9 strobe ignored without link", lit_a + lit_l, 0);
    link_up = 1'b1; speed = 2'b10; step(1);
    watch(12);
    check(dark_l == 0 && lit_a == 0, "R9 steady on link return", dark_l + lit_a, 0);
    pins("R5 dual 1000 steady", 1'b0, 1'b1);
    strobe(1'b1);
    watch(LEN + 2);
    check(lit_l > 0 && dark_l > 0, "R5 link pin blinks", dark_l, 1);
    check(lit_a == 0, "R5 act pin stays dark", lit_a, 0);
    step(6);
    speed = 2'b01; step(1);
    pins("R6 dual 100 steady", 1'b1, 1'b0);
    strobe(1'b0);
    watch(LEN + 2);
    check(lit_a > 0 && dark_a > 0, "R6 act pin blinks", dark_a, 1);
    check(lit_l == 0, "R6 link pin stays dark", lit_l, 0);
    step(6);
    speed = 2'b00; step(1);
    pins("R7 dual 10 steady", 1'b0, 1'b0);
    strobe(1'b1);
    watch(LEN + 2);
    check(uneq == 0, "R7 pins equal", uneq, 0);
    check(lit_a > 0 && dark_a > 0, "R7 both blink", dark_a, 1);
    step(6);
    speed = 2'b11; step(1);
    pins("R5 speed code 11 is 1000", 1'b0, 1'b1);
  endtask

  task automatic t_speed_change;
    do_reset(1'b1);
    link_up = 1'b1; speed = 2'b10; step(2);
    strobe(1'b0);
    step(3);
    speed = 2'b01; step(1);
    check(led_link_n == 1'b1, "R10 pattern updates next clock", led_link_n, 1);
    watch(11);
    check(lit_a > 0 && dark_a > 0, "R10 activity continues", dark_a, 1);
    check(lit_l == 0, "R10 old lit pin dark", lit_l, 0);
  endtask

  task automatic t_link_drop;
    do_reset(1'b1);
    link_up = 1'b1; speed = 2'b00; step(2);
    strobe(1'b0);
    step(3);
    link_up = 1'b0; step(1);
    pins("R9 link drop dark next clock", 1'b1, 1'b1);
    link_up = 1'b1; step(1);
    watch(LEN);
    check(dark_a == 0 && dark_l == 0, "R9 no blink after relink", dark_a + dark_l, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_strap = 1'b0; link_up = 1'b0; speed = 2'b00;
    tx_act = 1'b0; rx_act = 1'b0;
    step(1);
    t_single_link();
    t_single_act();
    t_strap_hold();
    t_dual();
    t_speed_change();
    t_link_drop();
    finish_run();
  end

endmodule